// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is one output-compare channel that sits next to two free-running 16-bit timers. It holds a compare value and checks it against the count of one of the two timers, chosen by a select input. When the selected count first becomes equal to the compare value, the channel acts according to a 4-bit mode. It can set, clear or toggle an output latch, raise only an interrupt, or fire a special event. The special event resets the selected timer, so the compare value works as a programmable period, and it can also start an analog-to-digital conversion.

Software writes the compare value and the mode through write strobes. The timers and the converter are outside the block. The channel only supplies one-cycle reset pulses, one per timer, and a conversion-start pulse. The latch reaches the pin only while the pin direction is set to output. A sticky interrupt flag stays set until it is cleared through a dedicated clear input.

Top module: `tmr_cmp_unit`

## Requirements
- R1: The compare value is checked against timer A's count when `tmr_sel_i`=0 and against timer B's count when `tmr_sel_i`=1. An equal count on the unselected timer has no effect.
- R2: With mode 4'b1000 a match drives the latch high, and with mode 4'b1001 a match drives it low. Writing a nonzero mode leaves the latch as it was.
- R3: With mode 4'b0010 each match inverts the latch.
- R4: Modes 4'b1000, 4'b1001, 4'b0010, 4'b1010 and 4'b1011 are the compare modes. In any of them a match sets the flag. Every other code takes no action on a match: flag, latch and pulses stay unchanged.
- R5: The flag holds until `flag_clr_i` is high on a clock edge. A clear and a match in the same cycle leave the flag set.
- R6: With mode 4'b1010 a match sets only the flag and leaves the latch unchanged.
- R7: With mode 4'b1011 a match gives a one-cycle pulse on `tmr_a_rst_o` when timer A is selected, or on `tmr_b_rst_o` when timer B is selected. The pulse is high in the cycle after the match cycle.
- R8: The special event pulses `adc_start_o` together with the timer reset only when the parameter `ADC_CAPABLE` is 1 and `adc_en_i` is high in the match cycle. A channel built with `ADC_CAPABLE`=0 never pulses it.
- R9: Writing mode 4'b0000 forces the latch low on the next edge, with or without a match.
- R10: `pin_en_o` follows `pin_oe_i`. `pin_o` shows the latch while `pin_oe_i` is high and is 0 otherwise.
- R11: A match is acted on only in the first cycle of equality. A count that stays equal does not toggle again or pulse again.
- R12: A compare write takes effect on the next edge. A match against the new value is detected in the cycle after the write, so the outputs respond two edges after the write when the count already equals the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmr_a_i | input | 16 | Timer A count |
| tmr_b_i | input | 16 | Timer B count |
| tmr_sel_i | input | 1 | Time base select, 0 = A, 1 = B |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | 16 | Compare value write data |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 4 | Mode write data |
| adc_en_i | input | 1 | Converter enabled |
| pin_oe_i | input | 1 | Pin direction, 1 = output |
| flag_clr_i | input | 1 | Interrupt flag clear |
| pin_o | output | 1 | Pin value |
| pin_en_o | output | 1 | Pin output enable |
| flag_o | output | 1 | Interrupt flag |
| tmr_a_rst_o | output | 1 | Timer A reset pulse |
| tmr_b_rst_o | output | 1 | Timer B reset pulse |
| adc_start_o | output | 1 | Conversion start pulse |

## Verification
The bench holds the count equal to the compare value for several cycles. A design that acts on level equality instead of its rising edge would then keep toggling the latch or repeat the timer reset pulse. It matches only the unselected timer, which catches an inverted or ignored select, and it issues a clear in the same cycle as a match, where a design with the wrong priority would drop the flag. It writes a compare value that the count already equals and checks the cycle of the response. A second instance built without conversion capability catches a conversion pulse that leaks past the parameter.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
  typedef enum logic [3:0] {
    MODE_OFF    = 4'b0000,
    MODE_TOGGLE = 4'b0010,
    MODE_SET    = 4'b1000,
    MODE_CLR    = 4'b1001,
    MODE_IRQ    = 4'b1010,
    MODE_EVT    = 4'b1011
  } cmp_mode_e;

  typedef struct packed {
    logic arm;
    logic set;
    logic clr;
    logic tgl;
    logic evt;
  } cmp_act_t;

  function automatic cmp_act_t decode_mode(logic [3:0] m);
    cmp_act_t a;
    a = '0;
    unique case (m)
      MODE_SET:    begin a.arm = 1'b1; a.set = 1'b1; end
      MODE_CLR:    begin a.arm = 1'b1; a.clr = 1'b1; end
      MODE_TOGGLE: begin a.arm = 1'b1; a.tgl = 1'b1; end
      MODE_IRQ:    a.arm = 1'b1;
      MODE_EVT:    begin a.arm = 1'b1; a.evt = 1'b1; end
      default:     a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/tmr_cmp_match.sv
module tmr_cmp_match #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_a_i,
  input  logic [W-1:0] cnt_b_i,
  input  logic         sel_i,
  input  logic [W-1:0] cmp_i,
  input  logic         arm_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_sel;
  logic         eq, eq_q;

  assign cnt_sel = sel_i ? cnt_b_i : cnt_a_i;
  assign eq      = (cnt_sel == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  // rising edge of equality only
  assign hit_o = arm_i & eq & ~eq_q;

  // R11
  hit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
endmodule

// File: rtl/tmr_cmp_latch.sv
module tmr_cmp_latch
  import tmr_cmp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     force_low_i,
  input  logic     hit_i,
  input  cmp_act_t act_i,
  output logic     latch_o
);
  logic latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          latch_q <= 1'b0;
    else if (force_low_i) latch_q <= 1'b0;
    else if (hit_i) begin
      if (act_i.set)      latch_q <= 1'b1;
      else if (act_i.clr) latch_q <= 1'b0;
      else if (act_i.tgl) latch_q <= ~latch_q;
    end
  end

  assign latch_o = latch_q;

  // R9
  force_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low_i |=> !latch_o);
  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !force_low_i) |=> $stable(latch_o));
endmodule

// File: rtl/tmr_cmp_flag.sv
module tmr_cmp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R5
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  // R5
  flag_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tmr_cmp_pkg::*;
#(
  parameter int W           = 16,
  parameter int MW          = 4,
  parameter bit ADC_CAPABLE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  tmr_a_i,
  input  logic [W-1:0]  tmr_b_i,
  input  logic          tmr_sel_i,
  input  logic          cmp_we_i,
  input  logic [W-1:0]  cmp_wdata_i,
  input  logic          mode_we_i,
  input  logic [MW-1:0] mode_wdata_i,
  input  logic          adc_en_i,
  input  logic          pin_oe_i,
  input  logic          flag_clr_i,
  output logic          pin_o,
  output logic          pin_en_o,
  output logic          flag_o,
  output logic          tmr_a_rst_o,
  output logic          tmr_b_rst_o,
  output logic          adc_start_o
);
  logic [W-1:0]  cmp_q;
  logic [MW-1:0] mode_q;
  cmp_act_t      act;
  logic          hit, trig, latch;
  logic          rst_a_q, rst_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      mode_q <= '0;
    end else begin
      if (cmp_we_i)  cmp_q  <= cmp_wdata_i;
      if (mode_we_i) mode_q <= mode_wdata_i;
    end
  end

  assign act = decode_mode(4'(mode_q));

  tmr_cmp_match #(.W(W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_a_i (tmr_a_i),
    .cnt_b_i (tmr_b_i),
    .sel_i   (tmr_sel_i),
    .cmp_i   (cmp_q),
    .arm_i   (act.arm),
    .hit_o   (hit)
  );

  tmr_cmp_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_low_i (mode_we_i && (mode_wdata_i == '0)),
    .hit_i       (hit),
    .act_i       (act),
    .latch_o     (latch)
  );

  tmr_cmp_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  assign trig = hit & act.evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= trig & ~tmr_sel_i;
      rst_b_q <= trig &  tmr_sel_i;
    end
  end

  generate
    if (ADC_CAPABLE) begin : g_adc
      logic adc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) adc_q <= 1'b0;
        else         adc_q <= trig & adc_en_i;
      end
      assign adc_start_o = adc_q;
    end else begin : g_no_adc
      assign adc_start_o = 1'b0;
    end
  endgenerate

  assign tmr_a_rst_o = rst_a_q;
  assign tmr_b_rst_o = rst_b_q;
  assign pin_en_o    = pin_oe_i;
  assign pin_o       = pin_oe_i & latch;

  // R7
  trig_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tmr_a_rst_o, tmr_b_rst_o}));
  // R7
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_a_rst_o || tmr_b_rst_o) |=> !(tmr_a_rst_o || tmr_b_rst_o));
  // R8
  adc_with_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> (tmr_a_rst_o || tmr_b_rst_o));
  // R4
  trig_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_a_rst_o || tmr_b_rst_o) |-> flag_o || $past(flag_clr_i));
endmodule

// File: tb/tb_tmr_cmp_unit.sv
module tb_tmr_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ta = '0, tb = '0, cmp_wd = '0;
  logic        sel = 1'b0, cmp_we = 1'b0, mode_we = 1'b0, adc_en = 1'b0;
  logic        oe = 1'b1, fclr = 1'b0;
  logic [3:0]  mode_wd = '0;
  logic        pin, pin_en, flag, ra, rb, ad;
  logic        pin2, pin_en2, flag2, ra2, rb2, ad2;
  int          checks = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tmr_cmp_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .tmr_a_i(ta), .tmr_b_i(tb), .tmr_sel_i(sel),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd), .mode_we_i(mode_we),
    .mode_wdata_i(mode_wd), .adc_en_i(adc_en), .pin_oe_i(oe), .flag_clr_i(fclr),
    .pin_o(pin), .pin_en_o(pin_en), .flag_o(flag), .tmr_a_rst_o(ra),
    .tmr_b_rst_o(rb), .adc_start_o(ad));

  tmr_cmp_unit #(.ADC_CAPABLE(1'b0)) dut_nc (
    .clk_i(clk), .rst_ni(rst_n), .tmr_a_i(ta), .tmr_b_i(tb), .tmr_sel_i(sel),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd), .mode_we_i(mode_we),
    .mode_wdata_i(mode_wd), .adc_en_i(adc_en), .pin_oe_i(oe), .flag_clr_i(fclr),
    .pin_o(pin2), .pin_en_o(pin_en2), .flag_o(flag2), .tmr_a_rst_o(ra2),
    .tmr_b_rst_o(rb2), .adc_start_o(ad2));

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] cmp;
    logic        sel;
    logic [15:0] ta;
    logic [15:0] tb;
    logic        adc;
    logic        oe;
    logic        pin;
    logic        flag;
    logic        ra;
    logic        rb;
    logic        ad;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'b1000, 16'h1234, 1'b0, 16'h1234, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 set
    '{4'b1001, 16'h0055, 1'b0, 16'h0055, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 clear
    '{4'b0010, 16'h7000, 1'b1, 16'h0000, 16'h7000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 toggle on B
    '{4'b1010, 16'h0200, 1'b0, 16'h0200, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 irq only
    '{4'b1011, 16'h0300, 1'b0, 16'h0300, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R7 R8 event A
    '{4'b1011, 16'h0400, 1'b1, 16'h0000, 16'h0400, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 R8 event B no adc
    '{4'b1011, 16'h0500, 1'b1, 16'h0000, 16'h0500, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 R8 event B adc
    '{4'b1000, 16'h0600, 1'b1, 16'h0600, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 unselected match
    '{4'b0111, 16'h0700, 1'b0, 16'h0700, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 non-compare code
    '{4'b1000, 16'h0800, 1'b0, 16'h0800, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R10 pin gated
    '{4'b1000, 16'hFFFF, 1'b1, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 top value on B
    '{4'b0000, 16'h0900, 1'b0, 16'h0900, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R4 off
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_mode(input logic [3:0] m);
    mode_we = 1'b1; mode_wd = m; step(); mode_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // reset state
    chk("R10 reset pin", {15'd0, pin}, 16'd0);
    chk("R5 reset flag", {15'd0, flag}, 16'd0);
    chk("R7 reset pulses", {13'd0, ra, rb, ad}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      // cycle 1: clear latch and flag, load compare, counts away from it
      oe = v.oe; adc_en = v.adc; sel = v.sel;
      ta = v.cmp ^ 16'h8000; tb = v.cmp ^ 16'h8000;
      mode_we = 1'b1; mode_wd = 4'b0000; fclr = 1'b1;
      cmp_we = 1'b1; cmp_wd = v.cmp;
      step();
      fclr = 1'b0; cmp_we = 1'b0;
      mode_wd = v.mode;
      step();
      mode_we = 1'b0;
      ta = v.ta; tb = v.tb;
      step();
      chk($sformatf("R%0d vec%0d pin", 0, i), {15'd0, pin}, {15'd0, v.pin});
      chk($sformatf("vec%0d pin_en R10", i), {15'd0, pin_en}, {15'd0, v.oe});
      chk($sformatf("vec%0d flag R4", i), {15'd0, flag}, {15'd0, v.flag});
      chk($sformatf("vec%0d rst_a R7", i), {15'd0, ra}, {15'd0, v.ra});
      chk($sformatf("vec%0d rst_b R7", i), {15'd0, rb}, {15'd0, v.rb});
      chk($sformatf("vec%0d adc R8", i), {15'd0, ad}, {15'd0, v.ad});
      chk($sformatf("vec%0d adc no-cap R8", i), {15'd0, ad2}, 16'd0);
      step();
      // stalled count: no refire R11
      chk($sformatf("vec%0d stall pulses R11", i), {13'd0, ra, rb, ad}, 16'd0);
      chk($sformatf("vec%0d stall pin R11", i), {15'd0, pin}, {15'd0, v.pin});
    end

    // R2: set then clear with a nonzero mode write between
    oe = 1'b1; sel = 1'b0; adc_en = 1'b0;
    ta = 16'd0;
    mode_we = 1'b1; mode_wd = 4'b0000; fclr = 1'b1; cmp_we = 1'b1; cmp_wd = 16'd100;
    step(); fclr = 1'b0; cmp_we = 1'b0;
    wr_mode(4'b1000);
    ta = 16'd100; step();
    chk("R2 set", {15'd0, pin}, 16'd1);
    ta = 16'd101; step();
    wr_mode(4'b1001);
    chk("R2 nonzero mode write keeps latch", {15'd0, pin}, 16'd1);
    ta = 16'd100; step();
    chk("R2 clear", {15'd0, pin}, 16'd0);

    // R3 / R11: toggle, stall, toggle back, toggle again
    ta = 16'd101; wr_mode(4'b0010);
    ta = 16'd100; step();
    chk("R3 toggle up", {15'd0, pin}, 16'd1);
    step(); step(); step();
    chk("R11 stalled count holds", {15'd0, pin}, 16'd1);
    ta = 16'd101; step();
    ta = 16'd100; step();
    chk("R3 toggle down", {15'd0, pin}, 16'd0);
    ta = 16'd101; step();
    ta = 16'd100; step();
    chk("R3 toggle up again", {15'd0, pin}, 16'd1);

    // R5: clear alone, then clear together with a match
    fclr = 1'b1; ta = 16'd101; step(); fclr = 1'b0;
    chk("R5 clear", {15'd0, flag}, 16'd0);
    step();
    chk("R5 stays clear", {15'd0, flag}, 16'd0);
    ta = 16'd100; fclr = 1'b1; step(); fclr = 1'b0;
    chk("R5 match beats clear", {15'd0, flag}, 16'd1);

    // R9: mode zero forces latch low with no match
    fclr = 1'b1; wr_mode(4'b0000); fclr = 1'b0;
    chk("R9 mode zero forces low", {15'd0, pin}, 16'd0);

    // R12: write a compare value equal to the present count
    wr_mode(4'b1000);
    ta = 16'd500; step();
    cmp_we = 1'b1; cmp_wd = 16'd500; step(); cmp_we = 1'b0;
    chk("R12 write edge no flag", {15'd0, flag}, 16'd0);
    chk("R12 write edge no set", {15'd0, pin}, 16'd0);
    step();
    chk("R12 match next cycle flag", {15'd0, flag}, 16'd1);
    chk("R12 match next cycle pin", {15'd0, pin}, 16'd1);

    // R10: turning the direction off hides the latch
    oe = 1'b0; #1;
    chk("R10 pin gated", {15'd0, pin}, 16'd0);
    chk("R10 pin_en", {15'd0, pin_en}, 16'd0);
    oe = 1'b1; #1;
    chk("R10 pin restored", {15'd0, pin}, 16'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule